// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block walks a circular list of two-word transmit descriptors held in memory, fetches the frame bytes each descriptor points at, and hands them one byte at a time to a downstream transmit path over a valid/ready byte stream. The stream carries an end-of-frame marker and a flag that tells the downstream path whether to skip appending a checksum. When a frame has been sent, the block writes a status word back into the frame's first descriptor, which hands that descriptor back to software.

Software fills descriptors, clears their ownership bit and issues a start pulse. The block then works through consecutive descriptors. It stops when it meets a descriptor whose ownership bit is still set. A halt pulse makes it finish the frame in progress and then go idle. If the ring runs dry in the middle of a frame, the frame is aborted and the abort is recorded in the write-back. An underrun reported by the downstream path during a frame is recorded in the same way.

Memory is reached through a single-port, byte-addressed, word-wide interface with a one-cycle read latency. Descriptor `k` sits at `ring_base + 8*k`. Word 0 of a descriptor holds the buffer address and word 1 holds the control and status bits.

Top module: `tdr_tx_dma`

## Requirements
- R1: While reset is held and after it is released, `busy`, `out_valid`, `mem_rd` and `mem_wr` are all low until a start pulse arrives, and the current descriptor is the one at `ring_base`.
- R2: Descriptor word 0 at offset +0 holds the buffer byte address, which must be word aligned. Word 1 at offset +4 holds the control word, whose bits 10:0 give the buffer length (1 to 2047 bytes). Buffer bytes leave in address order, with the byte at the lowest address of each memory word sent first. Every memory access is word aligned.
- R3: `out_last` is high only on the final byte of a buffer whose control bit 15 is set. `out_nocrc` equals control bit 16 of the buffer being streamed.
- R4: A start pulse while idle begins fetching at the current descriptor. A control word with bit 31 set, met at a frame boundary, stops the block without a write-back and leaves the current descriptor unchanged, so the next start fetches it again.
- R5: After the last buffer of a frame has been streamed, the block writes the first descriptor's control word back. The written word keeps the fetched bits, clears bits 29:27 and sets bit 31. Bit 28 is set if an underrun was recorded and bit 29 is always written as 0. Later descriptors of the frame are not written.
- R6: After a descriptor whose control bit 30 is set, the next fetch uses `ring_base`. Otherwise the next fetch uses the following 8-byte slot.
- R7: If a control word with bit 31 set is fetched in the middle of a frame, no more bytes are sent and no `out_last` is given. The first descriptor is written back with bits 31 and 27 set, and `busy` falls.
- R8: An `underrun_in` pulse while busy sets bit 28 in the write-back of the frame in progress. The flag is cleared for the next frame.
- R9: A halt pulse while busy lets the current frame complete with its write-back, then `busy` falls and no new frame begins even if the next descriptor is ready. The next start resumes at that descriptor.
- R10: A start pulse while busy has no effect on the byte stream or on the write-backs.
- R11: While `out_valid` is high and `out_ready` is low, `out_data`, `out_last` and `out_nocrc` hold their values and `out_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_base | input | AW | Byte address of descriptor 0 |
| start | input | 1 | Start pulse, taken only while idle |
| halt | input | 1 | Halt pulse, acts at the next frame boundary |
| underrun_in | input | 1 | Underrun report from the downstream path |
| busy | output | 1 | High from start until the block stops |
| mem_rd | output | 1 | Memory read strobe; data returns the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data (status write-back) |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| out_valid | output | 1 | Byte stream valid |
| out_ready | input | 1 | Byte stream ready |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of a frame |
| out_nocrc | output | 1 | Downstream must not append a checksum |

## Verification
The bench targets the frame boundaries. A buffer split across descriptors must show exactly one end marker and exactly one write-back, to the first descriptor. A design that marked every buffer's end, or that wrote back every descriptor, shows extra markers or extra writes. The wrap test places a ready descriptor just past the ring end, so a block that ignores the wrap bit streams bytes it should never see. The ring-dry, halt and start-while-busy cases check the byte count and the write-back log: a design that restarts mid-frame repeats bytes, one that halts mid-frame truncates them, and one that ignores the halt runs into the next frame. Random back-pressure checks that a stalled byte is held until it is taken.

// File: rtl/tdr_pkg.sv
// Package: descriptor control-word bit positions, FSM state type and the
// status write-back composer shared by the transmit ring reader.
package tdr_pkg;
    localparam int LEN_W      = 11;
    localparam int LAST_BIT   = 15;
    localparam int NOCRC_BIT  = 16;
    localparam int EXH_BIT    = 27;
    localparam int URUN_BIT   = 28;
    localparam int RETRY_BIT  = 29;
    localparam int WRAP_BIT   = 30;
    localparam int USED_BIT   = 31;

    typedef enum logic [3:0] {
        S_IDLE, S_RDC, S_WTC, S_RDA, S_WTA, S_RDW, S_WTW, S_SEND, S_NEXT, S_WB
    } tdr_state_e;

    // Build the status word written back into a frame's first descriptor.
    function automatic logic [31:0] wb_word(input logic [31:0] ctrl,
                                            input logic urun,
                                            input logic exh);
        logic [31:0] w;
        w = ctrl;
        w[EXH_BIT]   = exh;
        w[URUN_BIT]  = urun;
        w[RETRY_BIT] = 1'b0;
        w[USED_BIT]  = 1'b1;
        return w;
    endfunction
endpackage

// File: rtl/tdr_ring_ptr.sv
// Ring pointer: holds the current descriptor address and the address of the
// first descriptor of the frame in progress.
// Assumes ring_base is stable while reset is applied and while busy.
module tdr_ring_ptr #(
    parameter int AW   = 32,
    parameter int STEP = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic          advance,
    input  logic          wrap,
    input  logic          mark_first,
    output logic [AW-1:0] cur_ptr,
    output logic [AW-1:0] first_ptr
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    // Step or wrap the current pointer; remember the frame's first slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ptr   <= ring_base;
            first_ptr <= ring_base;
        end else begin
            if (advance)
                cur_ptr <= wrap ? ring_base : cur_ptr + STEP_V;
            if (mark_first)
                first_ptr <= cur_ptr;
        end
    end
endmodule

// File: rtl/tdr_byte_unpack.sv
// Byte unpacker: takes one memory word with a count of valid bytes and
// presents them lowest byte first on a valid/ready stream.
// Assumes load is only asserted while count is zero.
module tdr_byte_unpack #(
    parameter int WORD_BYTES = 4,
    localparam int DW = 8 * WORD_BYTES,
    localparam int CW = $clog2(WORD_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_word,
    input  logic [CW-1:0] load_cnt,
    input  logic          take,
    output logic [7:0]    byte_o,
    output logic          valid,
    output logic [CW-1:0] count
);
    logic [DW-1:0] shreg;

    // Load a word or shift out one byte per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            count <= '0;
        end else if (load) begin
            shreg <= load_word;
            count <= load_cnt;
        end else if (take && count != '0) begin
            shreg <= shreg >> 8;
            count <= count - CW'(1);
        end
    end

    assign byte_o = shreg[7:0];
    assign valid  = (count != '0);
endmodule

// File: rtl/tdr_tx_dma.sv
// Transmit descriptor ring reader (top). Fetches descriptors, streams buffer
// bytes, writes status into each frame's first descriptor, and handles
// start, halt, ring-dry abort and underrun recording.
// Assumes memory read data arrives one cycle after mem_rd, buffers are word
// aligned and lengths are non-zero for the last buffer of a frame.
module tdr_tx_dma
    import tdr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ring_base,
    input  logic          start,
    input  logic          halt,
    input  logic          underrun_in,
    output logic          busy,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [7:0]    out_data,
    output logic          out_last,
    output logic          out_nocrc
);
    localparam int WORD_BYTES = 4;
    localparam int DESC_BYTES = 2 * WORD_BYTES;
    localparam int CW         = $clog2(WORD_BYTES + 1);
    localparam logic [AW-1:0] CTRL_OFS = AW'(WORD_BYTES);

    tdr_state_e       state;
    logic             in_frame, halt_pend, urun, abort_f;
    logic             cur_last, cur_nocrc, cur_wrap;
    logic [31:0]      first_ctrl;
    logic [AW-1:2]    buf_ptr;
    logic [LEN_W-1:0] remain;
    logic [AW-1:0]    cur_ptr, first_ptr;
    logic [CW-1:0]    ub_count, load_cnt;
    logic             ub_valid, take, halt_now;
    logic             unused_rdata;

    assign unused_rdata = ^{mem_rdata[1:0]};
    assign halt_now = !in_frame && halt_pend;
    assign take     = out_valid && out_ready;
    assign load_cnt = (remain >= LEN_W'(WORD_BYTES)) ? CW'(WORD_BYTES)
                                                     : CW'(remain[1:0]);

    tdr_ring_ptr #(.AW(AW), .STEP(DESC_BYTES)) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ring_base  (ring_base),
        .advance    (state == S_NEXT),
        .wrap       (cur_wrap),
        .mark_first (state == S_WTC && !mem_rdata[USED_BIT] && !in_frame),
        .cur_ptr    (cur_ptr),
        .first_ptr  (first_ptr)
    );

    tdr_byte_unpack #(.WORD_BYTES(WORD_BYTES)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state == S_WTW),
        .load_word (mem_rdata),
        .load_cnt  (load_cnt),
        .take      (take),
        .byte_o    (out_data),
        .valid     (ub_valid),
        .count     (ub_count)
    );

    // Sequence descriptor fetches, buffer reads, streaming and write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            in_frame   <= 1'b0;
            halt_pend  <= 1'b0;
            urun       <= 1'b0;
            abort_f    <= 1'b0;
            cur_last   <= 1'b0;
            cur_nocrc  <= 1'b0;
            cur_wrap   <= 1'b0;
            first_ctrl <= '0;
            buf_ptr    <= '0;
            remain     <= '0;
        end else begin
            if (halt && state != S_IDLE)
                halt_pend <= 1'b1;
            if (underrun_in && state != S_IDLE)
                urun <= 1'b1;
            case (state)
                S_IDLE: if (start) begin
                    state     <= S_RDC;
                    urun      <= 1'b0;
                    halt_pend <= 1'b0;
                    in_frame  <= 1'b0;
                end
                S_RDC: if (halt_now) begin
                    state     <= S_IDLE;
                    halt_pend <= 1'b0;
                end else begin
                    state <= S_WTC;
                end
                S_WTC: if (mem_rdata[USED_BIT]) begin
                    if (in_frame) begin
                        state   <= S_WB;
                        abort_f <= 1'b1;
                    end else begin
                        state     <= S_IDLE;
                        halt_pend <= 1'b0;
                    end
                end else begin
                    state     <= S_RDA;
                    cur_last  <= mem_rdata[LAST_BIT];
                    cur_nocrc <= mem_rdata[NOCRC_BIT];
                    cur_wrap  <= mem_rdata[WRAP_BIT];
                    remain    <= mem_rdata[LEN_W-1:0];
                    if (!in_frame)
                        first_ctrl <= mem_rdata;
                end
                S_RDA: state <= S_WTA;
                S_WTA: begin
                    buf_ptr <= mem_rdata[AW-1:2];
                    state   <= (remain == '0) ? S_NEXT : S_RDW;
                end
                S_RDW: state <= S_WTW;
                S_WTW: begin
                    remain  <= remain - LEN_W'(load_cnt);
                    buf_ptr <= buf_ptr + 1'b1;
                    state   <= S_SEND;
                end
                S_SEND: if (ub_count == '0)
                    state <= (remain != '0) ? S_RDW : S_NEXT;
                S_NEXT: if (cur_last) begin
                    state   <= S_WB;
                    abort_f <= 1'b0;
                end else begin
                    state    <= S_RDC;
                    in_frame <= 1'b1;
                end
                S_WB: begin
                    in_frame <= 1'b0;
                    urun     <= 1'b0;
                    if (abort_f) begin
                        state     <= S_IDLE;
                        halt_pend <= 1'b0;
                    end else begin
                        state <= S_RDC;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the memory port from the current state.
    always_comb begin
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = wb_word(first_ctrl, urun, abort_f);
        case (state)
            S_RDC: begin mem_rd = !halt_now; mem_addr = cur_ptr + CTRL_OFS; end
            S_RDA: begin mem_rd = 1'b1;      mem_addr = cur_ptr; end
            S_RDW: begin mem_rd = 1'b1;      mem_addr = {buf_ptr, 2'b00}; end
            S_WB:  begin mem_wr = 1'b1;      mem_addr = first_ptr + CTRL_OFS; end
            default: ;
        endcase
    end

    assign busy      = (state != S_IDLE);
    assign out_valid = ub_valid;
    assign out_last  = ub_valid && cur_last && remain == '0 && ub_count == CW'(1);
    assign out_nocrc = cur_nocrc;
endmodule

// File: rtl/tdr_tx_dma_chk.sv
// Checker for the transmit ring reader: port-level protocol properties.
module tdr_tx_dma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          out_valid,
    input logic          out_ready,
    input logic [7:0]    out_data,
    input logic          out_last,
    input logic          out_nocrc
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !out_valid));
    // R2
    aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00 && !(mem_rd && mem_wr)));
    // R5
    wb_used_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_wdata[31] && !mem_wdata[29]));
    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_last) && $stable(out_nocrc)));
endmodule

bind tdr_tx_dma tdr_tx_dma_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_nocrc(out_nocrc)
);

// File: tb/tdr_tx_dma_tb.sv
module tdr_tx_dma_tb;
    localparam int AW = 16;
    localparam logic [AW-1:0] BASE = 16'h0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, halt = 1'b0, underrun_in = 1'b0;
    logic busy, mem_rd, mem_wr, out_valid, out_last, out_nocrc;
    logic out_ready = 1'b1;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [7:0] out_data;

    always #2.5 clk = ~clk;

    tdr_tx_dma #(.AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ring_base(BASE), .start(start), .halt(halt),
        .underrun_in(underrun_in), .busy(busy), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last), .out_nocrc(out_nocrc)
    );

    int n_checks = 0, n_fails = 0;
    int hold_checks = 0, hold_fails = 0;
    int cycles = 0;

    logic [31:0] mem [0:1023];
    logic [7:0]  cap_data [0:1023];
    logic        cap_last [0:1023];
    logic        cap_ncrc [0:1023];
    int          cap_n = 0;
    logic [AW-1:0] wb_addr [0:63];
    logic [31:0]   wb_data [0:63];
    int          wb_n = 0;
    logic        bp_en = 1'b0;
    logic [7:0]  lfsr = 8'hA5;
    logic        prev_stall = 1'b0;
    logic [7:0]  prev_data = 8'h00;

    // memory model: one-cycle read latency, logged writes
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[11:2]];
        if (mem_wr) begin
            mem[mem_addr[11:2]] = mem_wdata;
            wb_addr[wb_n] = mem_addr;
            wb_data[wb_n] = mem_wdata;
            wb_n = wb_n + 1;
        end
    end

    // back-pressure generator
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready <= bp_en ? (lfsr[0] | lfsr[3]) : 1'b1;
    end

    // stream monitor and hold check, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && prev_stall) begin
            hold_checks++;
            if (!(out_valid && out_data == prev_data)) begin
                hold_fails++;
                $display("FAIL R11 stalled byte changed: got %h valid %b exp %h",
                         out_data, out_valid, prev_data);
            end
        end
        prev_stall = rst_n && out_valid && !out_ready;
        prev_data  = out_data;
        if (rst_n && out_valid && out_ready) begin
            cap_data[cap_n] = out_data;
            cap_last[cap_n] = out_last;
            cap_ncrc[cap_n] = out_nocrc;
            cap_n++;
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks + hold_checks, n_fails + hold_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got %0d cycles exp below 150000", cycles);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %h exp %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    task automatic set_desc(input int idx, input int addr, input logic [31:0] ctrl);
        mem[(int'(BASE) + 8*idx) >> 2]     = 32'(addr);
        mem[(int'(BASE) + 8*idx + 4) >> 2] = ctrl;
    endtask

    function automatic logic [31:0] ctl(input int len, input bit last,
                                        input bit nocrc, input bit wrap);
        logic [31:0] c;
        c = 32'(len);
        c[15] = last; c[16] = nocrc; c[30] = wrap;
        return c;
    endfunction

    task automatic init_mem();
        for (int i = 0; i < 1024; i++)
            mem[i] = {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
        for (int k = 0; k < 4; k++)
            set_desc(k, 0, 32'h8000_0000 | (k == 3 ? 32'h4000_0000 : 32'h0));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        init_mem();
        rst_n = 1'b1;
        @(negedge clk);
        cap_n = 0;
        wb_n = 0;
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20000 && busy; i++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic chk_bytes(input string tag, input int from, input int addr,
                             input int len, input bit last, input bit nocrc);
        for (int k = 0; k < len; k++) begin
            chk(cap_data[from+k] == pat(addr+k), {tag, " byte"}, cap_data[from+k], pat(addr+k));
            chk(cap_last[from+k] == (last && k == len-1), {tag, " last"},
                cap_last[from+k], (last && k == len-1));
            chk(cap_ncrc[from+k] == nocrc, {tag, " nocrc"}, cap_ncrc[from+k], nocrc);
        end
    endtask

    // R1: reset state
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !out_valid && !mem_rd && !mem_wr, "R1 in reset", busy, 0);
        do_reset();
        repeat (3) @(negedge clk);
        chk(!busy && !out_valid && !mem_rd && !mem_wr, "R1 after reset", {busy, out_valid, mem_rd, mem_wr}, 0);
    endtask

    // R2 R3 R5 R4: single-buffer frame, stop on used, resume
    task automatic t_basic();
        do_reset();
        set_desc(0, 'h400, ctl(5, 1, 0, 0));
        pulse_start(); wait_idle();
        chk(cap_n == 5, "R2 byte count", cap_n, 5);
        chk_bytes("R2 R3 basic", 0, 'h400, 5, 1, 0);
        chk(wb_n == 1 && wb_addr[0] == 16'h0104, "R5 wb addr", wb_addr[0], 16'h0104);
        chk(wb_data[0] == (ctl(5, 1, 0, 0) | 32'h8000_0000), "R5 wb data", wb_data[0], ctl(5, 1, 0, 0) | 32'h8000_0000);
        chk(!busy, "R4 stop on used", busy, 0);
        set_desc(1, 'h440, ctl(2, 1, 0, 0));
        pulse_start(); wait_idle();
        chk(cap_n == 7, "R4 resume count", cap_n, 7);
        chk_bytes("R4 resume", 5, 'h440, 2, 1, 0);
        chk(wb_n == 2 && wb_addr[1] == 16'h010C, "R4 resume wb", wb_addr[1], 16'h010C);
    endtask

    // R3 R5: two-buffer frame with nocrc
    task automatic t_multi();
        do_reset();
        set_desc(0, 'h480, ctl(3, 0, 1, 0));
        set_desc(1, 'h4C0, ctl(6, 1, 1, 0));
        pulse_start(); wait_idle();
        chk(cap_n == 9, "R3 multi count", cap_n, 9);
        chk_bytes("R3 multi b0", 0, 'h480, 3, 0, 1);
        chk_bytes("R3 multi b1", 3, 'h4C0, 6, 1, 1);
        chk(wb_n == 1 && wb_addr[0] == 16'h0104, "R5 single wb", wb_n, 1);
        chk(wb_data[0] == (ctl(3, 0, 1, 0) | 32'h8000_0000), "R5 wb first ctrl", wb_data[0], ctl(3, 0, 1, 0) | 32'h8000_0000);
        chk(mem[16'h010C >> 2] == ctl(6, 1, 1, 0), "R5 second untouched", mem[16'h010C >> 2], ctl(6, 1, 1, 0));
    endtask

    // R6: wrap to ring base
    task automatic t_wrap();
        do_reset();
        set_desc(0, 'h500, ctl(1, 1, 0, 0));
        set_desc(1, 'h504, ctl(1, 1, 0, 0));
        set_desc(2, 'h508, ctl(1, 1, 0, 0));
        set_desc(3, 'h50C, ctl(4, 1, 0, 1));
        set_desc(4, 'h540, ctl(3, 1, 0, 0));
        pulse_start(); wait_idle();
        chk(cap_n == 7, "R6 wrap count", cap_n, 7);
        chk_bytes("R6 wrap d3", 3, 'h50C, 4, 1, 0);
        chk(wb_n == 4 && wb_addr[3] == 16'h011C, "R6 wrap wb", wb_addr[3], 16'h011C);
    endtask

    // R7: ring dry mid-frame
    task automatic t_exhaust();
        do_reset();
        set_desc(0, 'h580, ctl(4, 0, 0, 0));
        pulse_start(); wait_idle();
        chk(cap_n == 4, "R7 count", cap_n, 4);
        chk_bytes("R7 bytes", 0, 'h580, 4, 0, 0);
        chk(wb_n == 1 && wb_addr[0] == 16'h0104, "R7 wb addr", wb_addr[0], 16'h0104);
        chk(wb_data[0] == (ctl(4, 0, 0, 0) | 32'h8800_0000), "R7 wb data", wb_data[0], ctl(4, 0, 0, 0) | 32'h8800_0000);
        chk(!busy, "R7 busy low", busy, 0);
    endtask

    // R8: underrun recorded for one frame only
    task automatic t_underrun();
        do_reset();
        set_desc(0, 'h600, ctl(40, 1, 0, 0));
        set_desc(1, 'h640, ctl(3, 1, 0, 0));
        pulse_start();
        repeat (10) @(negedge clk);
        underrun_in = 1'b1; @(negedge clk); underrun_in = 1'b0;
        wait_idle();
        chk(cap_n == 43, "R8 count", cap_n, 43);
        chk(wb_n == 2 && wb_data[0][28] == 1'b1, "R8 bit28 set", wb_data[0], ctl(40, 1, 0, 0) | 32'h9000_0000);
        chk(wb_data[1][28] == 1'b0, "R8 bit28 cleared", wb_data[1], ctl(3, 1, 0, 0) | 32'h8000_0000);
    endtask

    // R9: halt finishes frame, next start resumes
    task automatic t_halt();
        do_reset();
        set_desc(0, 'h680, ctl(8, 1, 0, 0));
        set_desc(1, 'h6C0, ctl(4, 1, 0, 0));
        pulse_start();
        repeat (3) @(negedge clk);
        halt = 1'b1; @(negedge clk); halt = 1'b0;
        wait_idle();
        chk(cap_n == 8 && wb_n == 1, "R9 halted after frame", cap_n, 8);
        chk_bytes("R9 frame", 0, 'h680, 8, 1, 0);
        pulse_start(); wait_idle();
        chk(cap_n == 12 && wb_n == 2 && wb_addr[1] == 16'h010C, "R9 resume", cap_n, 12);
    endtask

    // R10: start while busy ignored
    task automatic t_start_busy();
        do_reset();
        set_desc(0, 'h700, ctl(12, 1, 0, 0));
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_start();
        wait_idle();
        chk(cap_n == 12, "R10 count", cap_n, 12);
        chk_bytes("R10 bytes", 0, 'h700, 12, 1, 0);
        chk(wb_n == 1, "R10 wb count", wb_n, 1);
    endtask

    // R11: random back-pressure
    task automatic t_backpressure();
        do_reset();
        set_desc(0, 'h740, ctl(20, 1, 1, 0));
        bp_en = 1'b1;
        pulse_start(); wait_idle();
        bp_en = 1'b0;
        chk(cap_n == 20, "R11 count", cap_n, 20);
        chk_bytes("R11 bytes", 0, 'h740, 20, 1, 1);
        chk(hold_checks > 0, "R11 stalls seen", hold_checks, 1);
    endtask

    initial begin
        init_mem();
        t_reset();
        t_basic();
        t_multi();
        t_wrap();
        t_exhaust();
        t_underrun();
        t_halt();
        t_start_busy();
        t_backpressure();
        finish_run();
    end
endmodule